// File: doc/BRIEF.md
# Windowed Remote Address Mapper

This block sits behind a local slave port and turns single-cycle local accesses into transfer requests for a remote bus. The upper part of the local slave space is carved into 64 windows of 1 MB each. Every window has its own programmable descriptor. The descriptor supplies the upper 12 remote address bits, a target space code, an interrupt-acknowledge flag and a 6-bit address modifier. The low 20 local address bits, the access width, the direction and the write data pass straight into the request.

Software programs the descriptors through a small register area in the same local space. A mapped access raises a request and holds it until the remote side answers. The remote completion status then becomes the outcome of the local cycle, so a remote bus error appears locally as a bus error.

An access is refused at once, with a local bus error and no remote request, in three cases: its descriptor holds a block-transfer address modifier, it falls outside both areas, or it uses the reserved width code. The link transport and the remote bus engine are outside this block.

Top module: `remote_window_mapper`

## Requirements
- R1: After reset every descriptor reads as zero, and `loc_done`, `loc_berr` and `rq_valid` are low.
- R2: Local addresses whose bits 31:8 equal 0x000004 reach descriptor number addr[7:2]. A write stores the descriptor and a read returns it. Only the defined fields are kept (bits 31:20, 13, 11:8 and 5:0, mask 0xFFF02F3F); other bits read as zero. The access ends with `loc_done` one cycle after the strobe, without `loc_berr` and without a remote request.
- R3: Local addresses whose bits 31:26 equal 6'b000001 are window accesses. Window number addr[25:20] selects the descriptor. `rq_addr` is descriptor bits 31:20 joined with local bits 19:0.
- R4: The request carries the space code from descriptor bits 11:8, the acknowledge flag from bit 13 and the modifier from bits 5:0. It also carries the local width code (0 byte, 1 word, 2 longword), the direction (`we`=1 write) and the write data, all unchanged.
- R5: `rq_valid` rises one cycle after an accepted window strobe. It stays high, with all request fields stable, until the cycle in which `rs_valid` is high, and falls one cycle later.
- R6: `loc_done` pulses for one cycle, one cycle after `rs_valid`. With status 0 there is no `loc_berr`, and a read returns `rs_rdata` on `loc_rdata`.
- R7: Any nonzero response status, including the remote bus error code 0x211, ends the local cycle with `loc_berr` together with `loc_done`.
- R8: A window whose descriptor modifier is a block-transfer code ends with `loc_done` and `loc_berr` one cycle after the strobe, and no request is issued. The block-transfer codes are 0x08, 0x0B, 0x0C, 0x0F, 0x38, 0x3B, 0x3C, 0x3F, 0x20 and 0x21.
- R9: An address outside both areas, or width code 3, ends with `loc_done` and `loc_berr` one cycle after the strobe, and no request is issued.
- R10: Strobes that arrive while a remote request is outstanding are ignored: no descriptor changes and no second request is issued.
- R11: Each window uses only its own descriptor. Two windows with different descriptors produce different remote addresses and attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_stb | input | 1 | One-cycle local access strobe |
| loc_we | input | 1 | Local direction, 1 = write |
| loc_addr | input | 32 | Local byte address within the block's slave space |
| loc_size | input | 2 | Local width: 0 byte, 1 word, 2 longword, 3 reserved |
| loc_wdata | input | 32 | Local write data |
| loc_done | output | 1 | One-cycle local completion |
| loc_berr | output | 1 | Local bus error, valid with loc_done |
| loc_rdata | output | 32 | Local read data, valid with loc_done |
| rq_valid | output | 1 | Remote request pending |
| rq_we | output | 1 | Remote direction |
| rq_addr | output | 32 | Remote address |
| rq_size | output | 2 | Remote width code |
| rq_space | output | 4 | Remote target space code |
| rq_iack | output | 1 | Interrupt-acknowledge cycle flag |
| rq_am | output | 6 | Remote address modifier |
| rq_wdata | output | 32 | Remote write data |
| rs_valid | input | 1 | One-cycle remote response |
| rs_status | input | 12 | Remote completion status, 0 = success |
| rs_rdata | input | 32 | Remote read data |

## Verification
The bench uses descriptors 0 and 63 and windows 62 and 63. A decoder that took its index from the wrong bit range would hit the wrong entry and return or send the wrong fields. It writes descriptor words with reserved bits set, so a table that kept or moved those bits would show it on readback. It sends each block-transfer modifier family, an unmapped address and the reserved width; a design that let any of these through would raise `rq_valid` where none may appear. While a request is outstanding, it strobes a descriptor write and checks afterwards that the descriptor is unchanged and that only one request was issued.

// File: rtl/rwm_pkg.sv
`timescale 1ns/1ps
package rwm_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int WIN_LOG2  = 20;
  localparam int HI_W      = ADDR_W - WIN_LOG2;
  localparam int SPACE_W   = 4;
  localparam int AM_W      = 6;
  localparam int STAT_W    = 12;
  localparam int SIZE_W    = 2;
  localparam int IACK_BIT  = 13;
  localparam int SPACE_LSB = 8;
  localparam int AM_LSB    = 0;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  // Stored form of a descriptor: only the defined fields
  typedef struct packed {
    logic [HI_W-1:0]    hi;
    logic               iack;
    logic [SPACE_W-1:0] space;
    logic [AM_W-1:0]    am;
  } desc_t;

  function automatic desc_t desc_from_word(input logic [DATA_W-1:0] w);
    desc_t d;
    d.hi    = w[ADDR_W-1:WIN_LOG2];
    d.iack  = w[IACK_BIT];
    d.space = w[SPACE_LSB +: SPACE_W];
    d.am    = w[AM_LSB +: AM_W];
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] desc_to_word(input desc_t d);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ADDR_W-1:WIN_LOG2]    = d.hi;
    w[IACK_BIT]             = d.iack;
    w[SPACE_LSB +: SPACE_W] = d.space;
    w[AM_LSB +: AM_W]       = d.am;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] remote_addr(input desc_t d,
                                                    input logic [WIN_LOG2-1:0] low);
    return {d.hi, low};
  endfunction

  // Block-transfer modifiers: BLT/MBLT in the A32 and A24 groups, plus double-edge codes
  function automatic logic am_is_block(input logic [AM_W-1:0] am);
    logic grp;
    grp = (am[5:3] == 3'b001) || (am[5:3] == 3'b111);
    return (grp && ((am[1:0] == 2'b00) || (am[1:0] == 2'b11))) ||
           (am[5:1] == 5'b10000);
  endfunction
endpackage

// File: rtl/rwm_decode.sv
`timescale 1ns/1ps
module rwm_decode
  import rwm_pkg::*;
#(
  parameter int NDESC    = 64,
  parameter int REG_BASE = 32'h0000_0400,
  parameter int WIN_BASE = 32'h0400_0000,
  localparam int IDX_W   = $clog2(NDESC)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              reg_hit,
  output logic              win_hit,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [IDX_W-1:0]  win_idx,
  output logic              size_ok
);
  localparam int REG_LSB = IDX_W + 2;
  localparam int WIN_LSB = WIN_LOG2 + IDX_W;
  localparam logic [ADDR_W-1:0] REG_B = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] WIN_B = ADDR_W'(WIN_BASE);

  assign reg_hit = (addr[ADDR_W-1:REG_LSB] == REG_B[ADDR_W-1:REG_LSB]);
  assign win_hit = (addr[ADDR_W-1:WIN_LSB] == WIN_B[ADDR_W-1:WIN_LSB]);
  assign reg_idx = addr[2 +: IDX_W];
  assign win_idx = addr[WIN_LOG2 +: IDX_W];
  assign size_ok = (size != SZ_RSVD);

  always_comb begin
    assert (!(reg_hit && win_hit)) else $error("AST_AREAS_DISJOINT"); // R9
  end
endmodule

// File: rtl/rwm_desc_table.sv
`timescale 1ns/1ps
module rwm_desc_table
  import rwm_pkg::*;
#(
  parameter int NDESC  = 64,
  localparam int IDX_W = $clog2(NDESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx_a,
  output logic [DATA_W-1:0] rd_word_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output desc_t             rd_desc_b
);
  desc_t ent [NDESC];
  desc_t wr_desc;

  assign wr_desc = desc_from_word(wr_word);

  for (genvar i = 0; i < NDESC; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[i] <= '0;
      else if (we && (wr_idx == IDX_W'(i)))
        ent[i] <= wr_desc;
    end
  end

  assign rd_word_a = desc_to_word(ent[rd_idx_a]);
  assign rd_desc_b = ent[rd_idx_b];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ent[$past(wr_idx)] == $past(wr_desc))); // R2
endmodule

// File: rtl/rwm_xfer_ctl.sv
`timescale 1ns/1ps
module rwm_xfer_ctl
  import rwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loc_stb,
  input  logic               loc_we,
  input  logic [ADDR_W-1:0]  loc_addr,
  input  logic [SIZE_W-1:0]  loc_size,
  input  logic [DATA_W-1:0]  loc_wdata,
  input  logic               reg_hit,
  input  logic               win_hit,
  input  logic               size_ok,
  input  desc_t              win_desc,
  input  logic [DATA_W-1:0]  reg_word,
  output logic               tbl_we,
  output logic               loc_done,
  output logic               loc_berr,
  output logic [DATA_W-1:0]  loc_rdata,
  output logic               rq_valid,
  output logic               rq_we,
  output logic [ADDR_W-1:0]  rq_addr,
  output logic [SIZE_W-1:0]  rq_size,
  output logic [SPACE_W-1:0] rq_space,
  output logic               rq_iack,
  output logic [AM_W-1:0]    rq_am,
  output logic [DATA_W-1:0]  rq_wdata,
  input  logic               rs_valid,
  input  logic [STAT_W-1:0]  rs_status,
  input  logic [DATA_W-1:0]  rs_rdata
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e state;

  // Named events for the assertions
  logic idle, take, blk_am, ev_reg, ev_win, ev_rej, ev_rej_am, ev_fin, rs_bad;

  assign idle      = (state == ST_IDLE);
  assign take      = idle && loc_stb;
  assign blk_am    = am_is_block(win_desc.am);
  assign ev_reg    = take && reg_hit && size_ok;
  assign ev_win    = take && win_hit && size_ok && !blk_am;
  assign ev_rej    = take && !ev_reg && !ev_win;
  assign ev_rej_am = take && win_hit && size_ok && blk_am;
  assign ev_fin    = !idle && rs_valid;
  assign rs_bad    = (rs_status != '0);
  assign tbl_we    = ev_reg && loc_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      loc_done  <= 1'b0;
      loc_berr  <= 1'b0;
      loc_rdata <= '0;
      rq_valid  <= 1'b0;
      rq_we     <= 1'b0;
      rq_addr   <= '0;
      rq_size   <= '0;
      rq_space  <= '0;
      rq_iack   <= 1'b0;
      rq_am     <= '0;
      rq_wdata  <= '0;
    end else begin
      loc_done <= 1'b0;
      loc_berr <= 1'b0;
      if (ev_reg) begin
        loc_done  <= 1'b1;
        loc_rdata <= loc_we ? '0 : reg_word;
      end
      if (ev_rej) begin
        loc_done  <= 1'b1;
        loc_berr  <= 1'b1;
        loc_rdata <= '0;
      end
      if (ev_win) begin
        state    <= ST_WAIT;
        rq_valid <= 1'b1;
        rq_we    <= loc_we;
        rq_addr  <= remote_addr(win_desc, loc_addr[WIN_LOG2-1:0]);
        rq_size  <= loc_size;
        rq_space <= win_desc.space;
        rq_iack  <= win_desc.iack;
        rq_am    <= win_desc.am;
        rq_wdata <= loc_wdata;
      end
      if (ev_fin) begin
        state     <= ST_IDLE;
        rq_valid  <= 1'b0;
        loc_done  <= 1'b1;
        loc_berr  <= rs_bad;
        loc_rdata <= rq_we ? '0 : rs_rdata;
      end
    end
  end

  AST_VALID_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid == !idle); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !rs_valid) |=> (rq_valid && $stable(rq_addr) && $stable(rq_am)
                                 && $stable(rq_space) && $stable(rq_wdata))); // R5
  AST_REQ_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rs_valid) |=> (!rq_valid && loc_done)); // R6
  AST_STATUS_TO_BERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rs_valid && rs_status != '0) |=> loc_berr); // R7
  AST_BERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    loc_berr |-> loc_done); // R7
  AST_BLOCK_AM_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rej_am |=> (!rq_valid && loc_done && loc_berr)); // R8
  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq_valid) |-> (rq_addr[WIN_LOG2-1:0] == $past(loc_addr[WIN_LOG2-1:0]))); // R3
  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> !tbl_we); // R10
endmodule

// File: rtl/remote_window_mapper.sv
`timescale 1ns/1ps
module remote_window_mapper
  import rwm_pkg::*;
#(
  parameter int NDESC    = 64,
  parameter int REG_BASE = 32'h0000_0400,
  parameter int WIN_BASE = 32'h0400_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loc_stb,
  input  logic        loc_we,
  input  logic [31:0] loc_addr,
  input  logic [1:0]  loc_size,
  input  logic [31:0] loc_wdata,
  output logic        loc_done,
  output logic        loc_berr,
  output logic [31:0] loc_rdata,
  output logic        rq_valid,
  output logic        rq_we,
  output logic [31:0] rq_addr,
  output logic [1:0]  rq_size,
  output logic [3:0]  rq_space,
  output logic        rq_iack,
  output logic [5:0]  rq_am,
  output logic [31:0] rq_wdata,
  input  logic        rs_valid,
  input  logic [11:0] rs_status,
  input  logic [31:0] rs_rdata
);
  localparam int IDX_W = $clog2(NDESC);

  logic              reg_hit, win_hit, size_ok, tbl_we;
  logic [IDX_W-1:0]  reg_idx, win_idx;
  logic [DATA_W-1:0] reg_word;
  desc_t             win_desc;

  rwm_decode #(.NDESC(NDESC), .REG_BASE(REG_BASE), .WIN_BASE(WIN_BASE)) u_dec (
    .addr(loc_addr), .size(loc_size),
    .reg_hit(reg_hit), .win_hit(win_hit),
    .reg_idx(reg_idx), .win_idx(win_idx), .size_ok(size_ok)
  );

  rwm_desc_table #(.NDESC(NDESC)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(tbl_we), .wr_idx(reg_idx), .wr_word(loc_wdata),
    .rd_idx_a(reg_idx), .rd_word_a(reg_word),
    .rd_idx_b(win_idx), .rd_desc_b(win_desc)
  );

  rwm_xfer_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .loc_stb(loc_stb), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_size(loc_size), .loc_wdata(loc_wdata),
    .reg_hit(reg_hit), .win_hit(win_hit), .size_ok(size_ok),
    .win_desc(win_desc), .reg_word(reg_word), .tbl_we(tbl_we),
    .loc_done(loc_done), .loc_berr(loc_berr), .loc_rdata(loc_rdata),
    .rq_valid(rq_valid), .rq_we(rq_we), .rq_addr(rq_addr), .rq_size(rq_size),
    .rq_space(rq_space), .rq_iack(rq_iack), .rq_am(rq_am), .rq_wdata(rq_wdata),
    .rs_valid(rs_valid), .rs_status(rs_status), .rs_rdata(rs_rdata)
  );

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!loc_done && !rq_valid)); // R1
endmodule

// File: tb/remote_window_mapper_test.sv
`timescale 1ns/1ps
module remote_window_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loc_stb = 1'b0, loc_we = 1'b0;
  logic [31:0] loc_addr = '0, loc_wdata = '0;
  logic [1:0]  loc_size = 2'd2;
  logic        loc_done, loc_berr;
  logic [31:0] loc_rdata;
  logic        rq_valid, rq_we, rq_iack;
  logic [31:0] rq_addr, rq_wdata;
  logic [1:0]  rq_size;
  logic [3:0]  rq_space;
  logic [5:0]  rq_am;
  logic        rs_valid = 1'b0;
  logic [11:0] rs_status = '0;
  logic [31:0] rs_rdata = '0;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  remote_window_mapper uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_addr(int idx);
    return 32'h400 + 32'(idx) * 4;
  endfunction

  function automatic logic [31:0] win_addr(int idx, logic [19:0] off);
    return 32'h0400_0000 | (32'(idx) << 20) | {12'h0, off};
  endfunction

  task automatic strobe(bit we, logic [31:0] a, logic [1:0] sz, logic [31:0] wd);
    @(negedge clk);
    loc_stb = 1'b1; loc_we = we; loc_addr = a; loc_size = sz; loc_wdata = wd;
    @(negedge clk);
    loc_stb = 1'b0;
  endtask

  task automatic reg_wr(int idx, logic [31:0] v);
    strobe(1'b1, reg_addr(idx), 2'd2, v);
    check("R2 write done", {31'h0, loc_done}, 32'h1);
    check("R2 write no berr", {31'h0, loc_berr}, 32'h0);
    check("R2 write no request", {31'h0, rq_valid}, 32'h0);
  endtask

  task automatic reg_rd(int idx, logic [31:0] exp, string tag);
    strobe(1'b0, reg_addr(idx), 2'd2, 32'h0);
    check({tag, " done"}, {31'h0, loc_done}, 32'h1);
    check({tag, " data"}, loc_rdata, exp);
  endtask

  task automatic remote(bit we, logic [31:0] a, logic [1:0] sz, logic [31:0] wd,
                        int lat, logic [11:0] st, logic [31:0] rd,
                        logic [31:0] e_addr, logic [3:0] e_space, bit e_iack,
                        logic [5:0] e_am, string tag);
    strobe(we, a, sz, wd);
    check({tag, " R5 rq_valid rises"}, {31'h0, rq_valid}, 32'h1);
    check({tag, " R3 rq_addr"}, rq_addr, e_addr);
    check({tag, " R4 space"}, {28'h0, rq_space}, {28'h0, e_space});
    check({tag, " R4 iack"}, {31'h0, rq_iack}, {31'h0, e_iack});
    check({tag, " R4 am"}, {26'h0, rq_am}, {26'h0, e_am});
    check({tag, " R4 size"}, {30'h0, rq_size}, {30'h0, sz});
    check({tag, " R4 dir"}, {31'h0, rq_we}, {31'h0, we});
    if (we) check({tag, " R4 wdata"}, rq_wdata, wd);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check({tag, " R5 held"}, {31'h0, rq_valid}, 32'h1);
      check({tag, " R5 addr stable"}, rq_addr, e_addr);
      check({tag, " R6 no early done"}, {31'h0, loc_done}, 32'h0);
    end
    rs_valid = 1'b1; rs_status = st; rs_rdata = rd;
    @(negedge clk);
    rs_valid = 1'b0; rs_status = '0; rs_rdata = '0;
    check({tag, " R6 done"}, {31'h0, loc_done}, 32'h1);
    check({tag, " R5 rq_valid falls"}, {31'h0, rq_valid}, 32'h0);
    if (st != 0) check({tag, " R7 berr"}, {31'h0, loc_berr}, 32'h1);
    else begin
      check({tag, " R6 no berr"}, {31'h0, loc_berr}, 32'h0);
      if (!we) check({tag, " R6 rdata"}, loc_rdata, rd);
    end
    @(negedge clk);
    check({tag, " R6 done one cycle"}, {31'h0, loc_done}, 32'h0);
  endtask

  task automatic reject(bit we, logic [31:0] a, logic [1:0] sz, string tag);
    strobe(we, a, sz, 32'hDEAD_BEEF);
    check({tag, " done"}, {31'h0, loc_done}, 32'h1);
    check({tag, " berr"}, {31'h0, loc_berr}, 32'h1);
    check({tag, " no request"}, {31'h0, rq_valid}, 32'h0);
    @(negedge clk);
    check({tag, " still no request"}, {31'h0, rq_valid}, 32'h0);
  endtask

  task automatic t_reset();
    check("R1 done low", {31'h0, loc_done}, 32'h0);
    check("R1 berr low", {31'h0, loc_berr}, 32'h0);
    check("R1 rq_valid low", {31'h0, rq_valid}, 32'h0);
    reg_rd(5, 32'h0, "R1 desc5 zero");
    reg_rd(63, 32'h0, "R1 desc63 zero");
  endtask

  task automatic t_regs();
    reg_wr(0, 32'hFFFF_FFFF);
    reg_rd(0, 32'hFFF0_2F3F, "R2 desc0 reserved masked");
    reg_wr(63, 32'h1234_5678);
    reg_rd(63, 32'h1234_5678 & 32'hFFF0_2F3F, "R2 desc63");
    reg_rd(0, 32'hFFF0_2F3F, "R2 desc0 untouched");
  endtask

  task automatic t_mapped();
    reg_wr(1, 32'h8760_0109);
    remote(1'b0, win_addr(1, 20'h0_1234), 2'd2, 32'h0, 3, 12'h000, 32'hCAFE_F00D,
           32'h8760_1234, 4'h1, 1'b0, 6'h09, "R6 long read");
    reg_wr(4, 32'h0010_2631);
    remote(1'b1, win_addr(4, 20'hF_FFFE), 2'd1, 32'h0000_A5A5, 0, 12'h000, 32'h0,
           32'h001F_FFFE, 4'h6, 1'b1, 6'h31, "R4 word write iack");
    reg_wr(2, 32'hABC0_000D);
    remote(1'b0, win_addr(2, 20'h0_0003), 2'd0, 32'h0, 1, 12'h000, 32'h0000_0077,
           32'hABC0_0003, 4'h0, 1'b0, 6'h0D, "R4 byte read");
  endtask

  task automatic t_errors();
    remote(1'b0, win_addr(1, 20'h0_0010), 2'd2, 32'h0, 2, 12'h211, 32'h1111_1111,
           32'h8760_0010, 4'h1, 1'b0, 6'h09, "R7 remote buserr");
    remote(1'b1, win_addr(1, 20'h0_0020), 2'd2, 32'h55, 0, 12'h103, 32'h0,
           32'h8760_0020, 4'h1, 1'b0, 6'h09, "R7 other status");
  endtask

  task automatic t_block_am();
    reg_wr(7, 32'h1000_010B);
    reject(1'b0, win_addr(7, 20'h0), 2'd2, "R8 am 0B");
    reg_wr(7, 32'h1000_013C);
    reject(1'b1, win_addr(7, 20'h4), 2'd2, "R8 am 3C");
    reg_wr(7, 32'h1000_0121);
    reject(1'b0, win_addr(7, 20'h8), 2'd2, "R8 am 21");
  endtask

  task automatic t_unmapped();
    reject(1'b0, 32'h0000_0010, 2'd2, "R9 low offset");
    reject(1'b1, 32'h0800_0000, 2'd2, "R9 above windows");
    reject(1'b0, win_addr(1, 20'h0), 2'd3, "R9 reserved width");
    reject(1'b1, reg_addr(3), 2'd3, "R9 reserved width reg");
  endtask

  task automatic t_busy_ignore();
    reg_wr(3, 32'h0A00_0109);
    reg_wr(9, 32'h0B00_0109);
    strobe(1'b0, win_addr(3, 20'h0_0100), 2'd2, 32'h0);
    check("R10 first request up", {31'h0, rq_valid}, 32'h1);
    strobe(1'b1, reg_addr(3), 2'd2, 32'hFFFF_FFFF);
    check("R10 no done while busy", {31'h0, loc_done}, 32'h0);
    strobe(1'b0, win_addr(9, 20'h0_0200), 2'd2, 32'h0);
    check("R10 addr unchanged", rq_addr, 32'h0A00_0100);
    rs_valid = 1'b1;
    @(negedge clk);
    rs_valid = 1'b0;
    check("R10 done", {31'h0, loc_done}, 32'h1);
    @(negedge clk);
    check("R10 no second request", {31'h0, rq_valid}, 32'h0);
    reg_rd(3, 32'h0A00_0109, "R10 desc3 unchanged");
  endtask

  task automatic t_independent();
    reg_wr(62, 32'h0620_0205);
    reg_wr(63, 32'h0630_2109);
    remote(1'b0, win_addr(62, 20'h0_0040), 2'd2, 32'h0, 0, 12'h000, 32'h6262_6262,
           32'h0620_0040, 4'h2, 1'b0, 6'h05, "R11 window 62");
    remote(1'b0, win_addr(63, 20'h0_0040), 2'd2, 32'h0, 0, 12'h000, 32'h6363_6363,
           32'h0630_0040, 4'h1, 1'b1, 6'h09, "R11 window 63");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mapped();
    t_errors();
    t_block_am();
    t_unmapped();
    t_busy_ignore();
    t_independent();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule